// File: doc/BRIEF.md
# Serial Flash Erase Sequencer

This block turns one erase request, given as a byte offset and a byte length, into a run of erase commands for a serial flash device whose pages need not be a power of two in size. The request also carries the page geometry: the page size in bytes and the number of bit positions by which a page number is shifted to form the device address. The block first divides the offset and the length by the page size with a shared bit-serial divider. It refuses the request if either value has a remainder.

For each step it picks one of two commands. A block erase covers eight pages and is used only when the current page sits on an eight-page boundary and at least eight pages remain. Otherwise it uses a single-page erase. After every erase command the block polls the device status with a separate frame and waits until the device reports ready. It inserts a configurable gap between polls and stops with a timeout error if the device stays busy too long.

The bit-level serial shifter sits outside the block. This block drives byte requests and chip-select framing, and it takes back one byte per acknowledge. The caller watches a busy flag and three one-cycle end pulses.

Top module: `flash_erase_seq`

## Requirements
- R1: A request whose byte offset or byte length is not a whole multiple of the page size, or whose page size is zero, ends with a one-cycle `errAlign` pulse. No chip-select frame is issued.
- R2: An aligned request with zero length ends with a one-cycle `done` pulse. No frame is issued.
- R3: The first byte of each erase frame is 0x50 (block erase) when the current page number has its three low bits zero and at least eight pages remain. Otherwise it is 0x81 (page erase).
- R4: An erase frame is exactly four bytes. Bytes two and three are bits 23..16 and 15..8 of (page number shifted left by `pageShift`), most significant first. The fourth byte is 0x00.
- R5: After each successful erase, the page number advances and the remaining length shrinks by eight pages or by one page, matching the command just issued. Erase frames continue until the remaining length is zero, and then `done` pulses.
- R6: After each erase frame the block issues status frames of two bytes: 0xD7, then a dummy 0x00 whose returned byte is the status. Only bit 7 (1 = ready) of that status byte is used. A status frame repeats until ready is read.
- R7: `spiReq` is high only while `spiCs` is high. A requested byte is held stable until `spiAck`. Chip select drops for at least one cycle between any two frames.
- R8: If ready has not been read once `TIMEOUT_CYCLES` cycles have passed since the end of the erase frame, the next not-ready status ends the request with a one-cycle `errTimeout` pulse. No further frame is issued.
- R9: Between two consecutive status frames, chip select stays low for at least `POLL_GAP` cycles.
- R10: `busy` is low out of reset and while idle, with chip select low. It rises after a request is accepted and stays high up to and including the cycle of the end pulse. A request presented while busy is ignored.
- R11: Each accepted request ends with exactly one of `done`, `errAlign` or `errTimeout`, each lasting one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start an erase; taken only while idle |
| reqOffset | input | OFS_W | Byte offset of the first byte to erase |
| reqLength | input | OFS_W | Number of bytes to erase |
| pageSize | input | PS_W | Page size in bytes |
| pageShift | input | SH_W | Shift from page number to device address |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse: erase finished |
| errAlign | output | 1 | One-cycle pulse: request not page aligned |
| errTimeout | output | 1 | One-cycle pulse: device stayed busy too long |
| spiCs | output | 1 | Chip select for the shifter, high = selected |
| spiReq | output | 1 | Byte transfer request |
| spiTxByte | output | 8 | Byte to send |
| spiAck | input | 1 | One-cycle acknowledge: byte exchanged |
| spiRxByte | input | 8 | Byte received, valid with `spiAck` |

## Verification
The checker watches the framing on every cycle. It confirms that a byte request never appears outside chip select and that a requested byte stays put until acknowledged. It also confirms that busy brackets the request and that exactly one single-cycle end pulse closes it. Which command is chosen at each page, the address bytes, the number of erase and status frames, the gap between polls and the timeout all depend on the request and on how the device answers. The bench's scenarios show these by logging every frame from a device model and comparing it against a byte-level reference walk of the request.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
  localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
  localparam logic [7:0] OP_STATUS      = 8'hD7;

  localparam int BLOCK_LOG   = 3;
  localparam int BLOCK_PAGES = 1 << BLOCK_LOG;
  localparam int READY_BIT   = 7;

  typedef enum logic [3:0] {
    S_IDLE,
    S_DIV_OFF,
    S_DIV_LEN,
    S_CHECK,
    S_CMD,
    S_CMD_GAP,
    S_STAT,
    S_DECIDE,
    S_POLL_WAIT,
    S_NEXT
  } seqState_t;

  typedef struct packed {
    logic load;
    logic divStartOff;
    logic divStartLen;
    logic byteClr;
    logic byteNext;
    logic statCap;
    logic advance;
    logic tmoClr;
    logic tmoRun;
    logic gapLoad;
    logic frameStat;
  } seqStrobe_t;

endpackage

// File: rtl/erase_div.sv
module erase_div #(
  parameter int DW = 24,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          done,
  output logic [DW-1:0] quotient,
  output logic [VW-1:0] remainder
);
  localparam int CW = $clog2(DW + 1);

  logic [VW-1:0] remR;
  logic [DW-1:0] quoR;
  logic [CW-1:0] cnt;
  logic          run;
  logic [VW:0]   trial;
  logic          fits;

  // restoring step: bring down the next dividend bit
  always_comb begin
    trial = {remR, quoR[DW-1]};
    fits  = (trial >= {1'b0, divisor});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remR <= '0;
      quoR <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        remR <= '0;
        quoR <= dividend;
        cnt  <= CW'(DW);
        run  <= 1'b1;
      end else if (run) begin
        remR <= VW'(fits ? (trial - {1'b0, divisor}) : trial);
        quoR <= {quoR[DW-2:0], fits};
        cnt  <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient  = quoR;
  assign remainder = remR;

endmodule

// File: rtl/erase_datapath.sv
module erase_datapath
  import flash_erase_pkg::*;
#(
  parameter int OFS_W          = 24,
  parameter int PS_W           = 11,
  parameter int SH_W           = 4,
  parameter int TIMEOUT_CYCLES = 400000000,
  parameter int POLL_GAP       = 600000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seqStrobe_t       stb,
  input  logic [OFS_W-1:0] reqOffset,
  input  logic [OFS_W-1:0] reqLength,
  input  logic [PS_W-1:0]  pageSize,
  input  logic [SH_W-1:0]  pageShift,
  input  logic [7:0]       rxByte,
  output logic [7:0]       txByte,
  output logic             divDone,
  output logic             misaligned,
  output logic             lenZero,
  output logic             lastByte,
  output logic             readyBit,
  output logic             timedOut,
  output logic             gapDone
);
  localparam int TMO_W = $clog2(TIMEOUT_CYCLES + 2);
  localparam int GAP_W = $clog2(POLL_GAP + 2);

  logic [OFS_W-1:0] lenReg;
  logic [PS_W-1:0]  psReg;
  logic [SH_W-1:0]  shReg;
  logic [OFS_W-1:0] pageNum;
  logic [OFS_W-1:0] pagesLeft;
  logic [PS_W-1:0]  offRem;
  logic [PS_W-1:0]  lenRem;
  logic             lenSel;
  logic [1:0]       byteIdx;
  logic [TMO_W-1:0] tmoCnt;
  logic [GAP_W-1:0] gapCnt;

  logic [OFS_W-1:0] divDividend;
  logic [PS_W-1:0]  divDivisor;
  logic [OFS_W-1:0] divQuot;
  logic [PS_W-1:0]  divRem;
  logic             useBlock;
  logic [OFS_W-1:0] stepPages;
  logic [15:0]      addrUpper;

  // the request is divided straight from the ports on acceptance
  assign divDividend = stb.load ? reqOffset : lenReg;
  assign divDivisor  = stb.load ? pageSize  : psReg;

  erase_div #(.DW(OFS_W), .VW(PS_W)) div_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (stb.divStartOff | stb.divStartLen),
    .dividend (divDividend),
    .divisor  (divDivisor),
    .done     (divDone),
    .quotient (divQuot),
    .remainder(divRem)
  );

  assign useBlock   = (pageNum[BLOCK_LOG-1:0] == '0) &&
                      (pagesLeft >= OFS_W'(BLOCK_PAGES));
  assign stepPages  = useBlock ? OFS_W'(BLOCK_PAGES) : OFS_W'(1);
  assign misaligned = (offRem != '0) || (lenRem != '0) || (psReg == '0);
  assign lenZero    = (pagesLeft == '0);
  assign addrUpper  = 16'((24'(pageNum) << shReg) >> 8);
  assign lastByte   = stb.frameStat ? (byteIdx == 2'd1) : (byteIdx == 2'd3);
  assign timedOut   = (tmoCnt >= TMO_W'(TIMEOUT_CYCLES));
  assign gapDone    = (gapCnt == '0);

  always_comb begin
    txByte = 8'h00;
    if (stb.frameStat) begin
      if (byteIdx == 2'd0) txByte = OP_STATUS;
    end else begin
      case (byteIdx)
        2'd0:    txByte = useBlock ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
        2'd1:    txByte = addrUpper[15:8];
        2'd2:    txByte = addrUpper[7:0];
        default: txByte = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lenReg    <= '0;
      psReg     <= '0;
      shReg     <= '0;
      pageNum   <= '0;
      pagesLeft <= '0;
      offRem    <= '0;
      lenRem    <= '0;
      lenSel    <= 1'b0;
      byteIdx   <= '0;
      readyBit  <= 1'b0;
      tmoCnt    <= '0;
      gapCnt    <= '0;
    end else begin
      if (stb.load) begin
        lenReg <= reqLength;
        psReg  <= pageSize;
        shReg  <= pageShift;
      end
      if (stb.divStartOff) lenSel <= 1'b0;
      if (stb.divStartLen) lenSel <= 1'b1;
      if (divDone) begin
        if (lenSel) begin
          pagesLeft <= divQuot;
          lenRem    <= divRem;
        end else begin
          pageNum <= divQuot;
          offRem  <= divRem;
        end
      end
      if (stb.advance) begin
        pageNum   <= pageNum + stepPages;
        pagesLeft <= pagesLeft - stepPages;
      end
      if (stb.byteClr)       byteIdx <= '0;
      else if (stb.byteNext) byteIdx <= byteIdx + 2'd1;
      if (stb.statCap) readyBit <= rxByte[READY_BIT];
      if (stb.tmoClr)                 tmoCnt <= '0;
      else if (stb.tmoRun && !timedOut) tmoCnt <= tmoCnt + 1'b1;
      if (stb.gapLoad)       gapCnt <= GAP_W'(POLL_GAP);
      else if (!gapDone)     gapCnt <= gapCnt - 1'b1;
    end
  end

endmodule

// File: rtl/erase_ctrl.sv
module erase_ctrl
  import flash_erase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       spiAck,
  input  logic       divDone,
  input  logic       misaligned,
  input  logic       lenZero,
  input  logic       lastByte,
  input  logic       readyBit,
  input  logic       timedOut,
  input  logic       gapDone,
  output seqStrobe_t stb,
  output logic       spiCs,
  output logic       spiReq,
  output logic       busy,
  output logic       done,
  output logic       errAlign,
  output logic       errTimeout
);
  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    nextState  = state;
    stb        = '0;
    spiCs      = 1'b0;
    spiReq     = 1'b0;
    done       = 1'b0;
    errAlign   = 1'b0;
    errTimeout = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.load        = 1'b1;
          stb.divStartOff = 1'b1;
          nextState       = S_DIV_OFF;
        end
      end
      S_DIV_OFF: begin
        if (divDone) begin
          stb.divStartLen = 1'b1;
          nextState       = S_DIV_LEN;
        end
      end
      S_DIV_LEN: begin
        if (divDone) nextState = S_CHECK;
      end
      S_CHECK: begin
        if (misaligned) begin
          errAlign  = 1'b1;
          nextState = S_IDLE;
        end else if (lenZero) begin
          done      = 1'b1;
          nextState = S_IDLE;
        end else begin
          stb.byteClr = 1'b1;
          nextState   = S_CMD;
        end
      end
      S_CMD: begin
        spiCs  = 1'b1;
        spiReq = 1'b1;
        if (spiAck) begin
          if (lastByte) begin
            stb.byteClr = 1'b1;
            stb.tmoClr  = 1'b1;
            nextState   = S_CMD_GAP;
          end else begin
            stb.byteNext = 1'b1;
          end
        end
      end
      S_CMD_GAP: begin
        stb.tmoRun = 1'b1;
        nextState  = S_STAT;
      end
      S_STAT: begin
        spiCs         = 1'b1;
        spiReq        = 1'b1;
        stb.frameStat = 1'b1;
        stb.tmoRun    = 1'b1;
        if (spiAck) begin
          if (lastByte) begin
            stb.statCap = 1'b1;
            stb.byteClr = 1'b1;
            nextState   = S_DECIDE;
          end else begin
            stb.byteNext = 1'b1;
          end
        end
      end
      S_DECIDE: begin
        stb.tmoRun = 1'b1;
        if (readyBit) begin
          stb.advance = 1'b1;
          nextState   = S_NEXT;
        end else if (timedOut) begin
          errTimeout = 1'b1;
          nextState  = S_IDLE;
        end else begin
          stb.gapLoad = 1'b1;
          nextState   = S_POLL_WAIT;
        end
      end
      S_POLL_WAIT: begin
        stb.tmoRun = 1'b1;
        if (gapDone) nextState = S_STAT;
      end
      S_NEXT: begin
        if (lenZero) begin
          done      = 1'b1;
          nextState = S_IDLE;
        end else begin
          stb.byteClr = 1'b1;
          nextState   = S_CMD;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int OFS_W          = 24,
  parameter int PS_W           = 11,
  parameter int SH_W           = 4,
  parameter int TIMEOUT_CYCLES = 400000000,
  parameter int POLL_GAP       = 600000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic [OFS_W-1:0] reqOffset,
  input  logic [OFS_W-1:0] reqLength,
  input  logic [PS_W-1:0]  pageSize,
  input  logic [SH_W-1:0]  pageShift,
  output logic             busy,
  output logic             done,
  output logic             errAlign,
  output logic             errTimeout,
  output logic             spiCs,
  output logic             spiReq,
  output logic [7:0]       spiTxByte,
  input  logic             spiAck,
  input  logic [7:0]       spiRxByte
);
  seqStrobe_t stb;
  logic divDone, misaligned, lenZero, lastByte, readyBit, timedOut, gapDone;

  erase_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .spiAck    (spiAck),
    .divDone   (divDone),
    .misaligned(misaligned),
    .lenZero   (lenZero),
    .lastByte  (lastByte),
    .readyBit  (readyBit),
    .timedOut  (timedOut),
    .gapDone   (gapDone),
    .stb       (stb),
    .spiCs     (spiCs),
    .spiReq    (spiReq),
    .busy      (busy),
    .done      (done),
    .errAlign  (errAlign),
    .errTimeout(errTimeout)
  );

  erase_datapath #(
    .OFS_W         (OFS_W),
    .PS_W          (PS_W),
    .SH_W          (SH_W),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .POLL_GAP      (POLL_GAP)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .reqOffset (reqOffset),
    .reqLength (reqLength),
    .pageSize  (pageSize),
    .pageShift (pageShift),
    .rxByte    (spiRxByte),
    .txByte    (spiTxByte),
    .divDone   (divDone),
    .misaligned(misaligned),
    .lenZero   (lenZero),
    .lastByte  (lastByte),
    .readyBit  (readyBit),
    .timedOut  (timedOut),
    .gapDone   (gapDone)
  );

endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       errAlign,
  input logic       errTimeout,
  input logic       spiCs,
  input logic       spiReq,
  input logic       spiAck,
  input logic [7:0] spiTxByte
);
  logic anyEnd;
  assign anyEnd = done | errAlign | errTimeout;

  assert_req_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spiReq |-> spiCs);

  assert_byte_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (spiReq && !spiAck) |=> (spiReq && $stable(spiTxByte)));

  assert_single_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, errAlign, errTimeout}));

  assert_end_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    anyEnd |=> !anyEnd);

  assert_end_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    anyEnd |-> busy);

  assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !anyEnd) |=> busy);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!spiCs && !spiReq));

endmodule

bind flash_erase_seq flash_erase_seq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .errAlign  (errAlign),
  .errTimeout(errTimeout),
  .spiCs     (spiCs),
  .spiReq    (spiReq),
  .spiAck    (spiAck),
  .spiTxByte (spiTxByte)
);

// File: tb/flash_erase_seq_tb_top.sv
module flash_erase_seq_tb_top;
  localparam int OFS_W    = 24;
  localparam int PS_W     = 11;
  localparam int SH_W     = 4;
  localparam int TMO      = 300;
  localparam int GAP      = 4;
  localparam int NVEC     = 11;
  localparam int LOGN     = 64;

  typedef struct packed {
    int off;
    int len;
    int ps;
    int sh;
    int expRes;    // 0 done, 1 align error
    int expFrames;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{0,        2112,  264,  9, 0, 1},   // one block
    '{264,      528,   264,  9, 0, 2},   // two pages
    '{1584,     2640,  264,  9, 0, 3},   // page, page, block
    '{2112,     1848,  264,  9, 0, 7},   // aligned but short of a block
    '{0,        4224,  264,  9, 0, 2},   // two blocks
    '{100,      264,   264,  9, 1, 0},   // offset misaligned
    '{0,        265,   264,  9, 1, 0},   // length misaligned
    '{0,        0,     264,  9, 0, 0},   // empty request
    '{8448,     4752,  528, 10, 0, 2},   // block then page
    '{3168,     1056, 1056, 11, 0, 1},   // single page, wide shift
    '{0,        512,     0,  9, 1, 0}    // zero page size
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [OFS_W-1:0] reqOffset = '0;
  logic [OFS_W-1:0] reqLength = '0;
  logic [PS_W-1:0]  pageSize = '0;
  logic [SH_W-1:0]  pageShift = '0;
  logic busy, done, errAlign, errTimeout, spiCs, spiReq;
  logic [7:0] spiTxByte;
  logic spiAck = 1'b0;
  logic [7:0] spiRxByte = 8'h00;

  always #2.5 clk = ~clk;

  flash_erase_seq #(
    .OFS_W(OFS_W), .PS_W(PS_W), .SH_W(SH_W),
    .TIMEOUT_CYCLES(TMO), .POLL_GAP(GAP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqOffset(reqOffset),
    .reqLength(reqLength), .pageSize(pageSize), .pageShift(pageShift),
    .busy(busy), .done(done), .errAlign(errAlign), .errTimeout(errTimeout),
    .spiCs(spiCs), .spiReq(spiReq), .spiTxByte(spiTxByte),
    .spiAck(spiAck), .spiRxByte(spiRxByte)
  );

  // ---------------- device model ----------------
  int   busyPolls = 1;
  logic clrLog = 1'b0;
  int   eraseCount, statCount, pollsLeft, minGap, lowRun, gapAtRise, fIdx, ackCnt;
  logic prevCs, lastWasStat;
  logic [7:0]  fBytes [4];
  logic [7:0]  eOp   [LOGN];
  logic [15:0] eAddr [LOGN];
  logic [7:0]  eLast [LOGN];
  int          eLen  [LOGN];

  always @(posedge clk) begin
    if (!rst_n) begin
      eraseCount <= 0; statCount <= 0; pollsLeft <= 0; minGap <= 1000;
      lowRun <= 0; gapAtRise <= 0; fIdx <= 0; ackCnt <= 0;
      prevCs <= 1'b0; lastWasStat <= 1'b0; spiAck <= 1'b0; spiRxByte <= 8'h00;
      for (int i = 0; i < 4; i++) fBytes[i] <= 8'h00;
    end else begin
      prevCs <= spiCs;
      spiAck <= 1'b0;
      lowRun <= spiCs ? 0 : lowRun + 1;
      if (spiCs && !prevCs) begin
        fIdx <= 0;
        gapAtRise <= lowRun;
      end
      if (spiReq && !spiAck) begin
        if (ackCnt == 1) begin
          ackCnt <= 0;
          spiAck <= 1'b1;
          if (fIdx < 4) fBytes[fIdx] <= spiTxByte;
          fIdx <= fIdx + 1;
          spiRxByte <= 8'h00;
          if (fIdx == 1 && fBytes[0] == 8'hD7) begin
            if (pollsLeft == 0) spiRxByte <= 8'hBC;
            else begin
              spiRxByte <= 8'h3C;
              pollsLeft <= pollsLeft - 1;
            end
          end
          if (fIdx == 0 && spiTxByte == 8'hD7 && lastWasStat && gapAtRise < minGap)
            minGap <= gapAtRise;
        end else begin
          ackCnt <= ackCnt + 1;
        end
      end
      if (!spiCs && prevCs) begin
        if (fBytes[0] == 8'hD7) begin
          statCount <= statCount + 1;
          lastWasStat <= 1'b1;
        end else begin
          if (eraseCount < LOGN) begin
            eOp[eraseCount]   <= fBytes[0];
            eAddr[eraseCount] <= {fBytes[1], fBytes[2]};
            eLast[eraseCount] <= fBytes[3];
            eLen[eraseCount]  <= fIdx;
          end
          eraseCount <= eraseCount + 1;
          pollsLeft <= busyPolls;
          lastWasStat <= 1'b0;
        end
      end
      if (clrLog) begin
        eraseCount <= 0; statCount <= 0; minGap <= 1000; lastWasStat <= 1'b0;
      end
    end
  end

  // ---------------- checking ----------------
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // result: 0 done, 1 align, 2 timeout, 3 none
  task automatic runReq(input int off, input int len, input int ps, input int sh,
                        input bit poke, output int res);
    bit busyLost;
    @(negedge clk) clrLog = 1'b1;
    @(negedge clk) clrLog = 1'b0;
    reqOffset = OFS_W'(off);
    reqLength = OFS_W'(len);
    pageSize  = PS_W'(ps);
    pageShift = SH_W'(sh);
    reqValid  = 1'b1;
    @(negedge clk) reqValid = 1'b0;
    res = 3;
    busyLost = 1'b0;
    for (int c = 0; c < 30000; c++) begin
      if (poke && c == 40) begin
        reqOffset = OFS_W'(100);
        reqValid = 1'b1;
      end else begin
        reqValid = 1'b0;
      end
      if (done || errAlign || errTimeout) begin
        res = done ? 0 : (errAlign ? 1 : 2);
        check(busy, "R10", "busy during end pulse", busy, 1);
        break;
      end
      if (!busy) busyLost = 1'b1;
      @(negedge clk);
    end
    reqValid = 1'b0;
    check(!busyLost, "R10", "busy dropped before end pulse", busyLost, 0);
    @(negedge clk);
    check(!done && !errAlign && !errTimeout, "R11", "end pulse longer than one cycle",
          {done, errAlign, errTimeout}, 0);
    check(!busy, "R10", "busy after end", busy, 0);
  endtask

  task automatic checkFrames(input int off, input int len, input int ps, input int sh);
    int o, l, k, pg;
    bit blk;
    logic [23:0] a;
    o = off; l = len; k = 0;
    while (l > 0 && k < LOGN) begin
      pg  = o / ps;
      blk = ((pg % 8) == 0) && (l >= 8 * ps);
      a   = 24'(pg) << sh;
      check(eOp[k] == (blk ? 8'h50 : 8'h81), "R3", "erase opcode", eOp[k], blk ? 8'h50 : 8'h81);
      check(eAddr[k] == a[23:8], "R4", "address bytes", eAddr[k], a[23:8]);
      check(eLast[k] == 8'h00 && eLen[k] == 4, "R4", "fourth byte / frame length",
            eLen[k] * 256 + eLast[k], 4 * 256);
      o = o + (blk ? 8 * ps : ps);
      l = l - (blk ? 8 * ps : ps);
      k++;
    end
  endtask

  initial begin
    int res;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !spiCs && !spiReq && !done && !errAlign && !errTimeout,
          "R10", "reset state", {busy, spiCs, spiReq, done, errAlign, errTimeout}, 0);

    // vector table
    busyPolls = 1;
    for (int v = 0; v < NVEC; v++) begin
      runReq(VECS[v].off, VECS[v].len, VECS[v].ps, VECS[v].sh, 1'b0, res);
      if (VECS[v].expRes == 1)
        check(res == 1, "R1", "misaligned request result", res, 1);
      else if (VECS[v].len == 0)
        check(res == 0, "R2", "empty request result", res, 0);
      else
        check(res == 0, "R5", "erase result", res, 0);
      check(eraseCount == VECS[v].expFrames, "R5", "erase frame count",
            eraseCount, VECS[v].expFrames);
      if (VECS[v].expFrames > 0) begin
        checkFrames(VECS[v].off, VECS[v].len, VECS[v].ps, VECS[v].sh);
        check(statCount == 2 * eraseCount, "R6", "status frames per erase",
              statCount, 2 * eraseCount);
      end else begin
        check(statCount == 0, "R1", "no frames on rejected/empty request", statCount, 0);
      end
    end

    // several busy polls before ready; status bits other than bit 7 ignored
    busyPolls = 3;
    runReq(264, 528, 264, 9, 1'b0, res);
    check(res == 0, "R6", "result after long poll", res, 0);
    check(statCount == 8, "R6", "status frames with three busy polls", statCount, 8);
    check(minGap >= GAP, "R9", "minimum gap between polls", minGap, GAP);

    // request presented while busy is ignored
    busyPolls = 2;
    runReq(0, 528, 264, 9, 1'b1, res);
    check(res == 0, "R10", "second request ignored", res, 0);
    check(eraseCount == 2, "R10", "erase frames with ignored request", eraseCount, 2);

    // device never ready: timeout
    busyPolls = 100000;
    runReq(2112, 2112, 264, 9, 1'b0, res);
    check(res == 2, "R8", "timeout result", res, 2);
    check(eraseCount == 1, "R8", "no erase after timeout", eraseCount, 1);
    check(statCount >= 2, "R8", "polled before giving up", statCount, 2);
    repeat (20) @(negedge clk);
    check(!spiCs && eraseCount == 1, "R8", "quiet after timeout", spiCs, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule